// File: doc/BRIEF.md
# UART Interrupt Mask and Status Controller

This block is the interrupt front end of a serial port. The transmit, receive and modem-line logic each raise single-cycle event pulses on fourteen source lines. Software chooses which sources may interrupt the processor. It writes ones to a set address to allow a source and ones to a clear address to block it. The current mask can be read back at its own address.

An event on an allowed source sets a sticky bit in the status register. The interrupt line is the OR of all status bits. Software acknowledges a source by writing a one to that bit at the status address. A live view returns the raw source lines whatever the mask holds, so firmware can poll sources it keeps blocked.

The register port is a simple word-indexed interface. A write takes effect at the clock edge where `wrEn` is high. The read data depends only on `addr` and the current state.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask (address 0x2) reads 0, the status (address 0x3) reads 0 and `irqOut` is low.
- R2: A write to address 0x0 sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to address 0x1 clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: Reads from addresses 0x0 and 0x1 always return zero.
- R5: A status bit is set only by an event on a source whose mask bit was already set before that edge. An event in the same cycle as the write that enables the source is not recorded.
- R6: Status bits are sticky. A write of 1 to a bit at address 0x3 clears it, a 0 data bit leaves it unchanged, and clearing the mask does not clear status.
- R7: If an event on an enabled source and a status clear of the same bit occur in the same cycle, the bit ends up set.
- R8: `irqOut` is registered and equals the OR of the status bits. It changes at the same clock edge as the status register.
- R9: A read of address 0x4 returns the present `srcEvt` lines, including masked sources.
- R10: Only bits 13..0 carry sources. Bit 0 is the receive-trigger source and bit 13 is the receive-break source. Data bits above 13 are ignored, and read bits above 13 are zero. Writes to address 0x2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word address for read and write |
| wrData | input | 32 | Write data |
| srcEvt | input | 14 | Raw event lines from the serial port logic |
| rdData | output | 32 | Read data for `addr` |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
A mask bit in the wrong state is seen at the ports only when an event arrives on that source: the status bit and the interrupt are either missed or raised in error, one edge after the event. The mask readback shows the fault earlier, at the first read that follows. A status bit that fails to stick, or that is lost when a clear and an event collide, drops `irqOut` at the edge after that cycle. The same-edge enable-and-event case tests whether status is gated by the old mask or the new one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N  = 14;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  // source positions; bit 0 is the lowest source
  localparam int SRC_RX_TRIG   = 0;
  localparam int SRC_RX_EMPTY  = 1;
  localparam int SRC_RX_FULL   = 2;
  localparam int SRC_TX_EMPTY  = 3;
  localparam int SRC_TX_FULL   = 4;
  localparam int SRC_OVERRUN   = 5;
  localparam int SRC_FRAMING   = 6;
  localparam int SRC_PARITY    = 7;
  localparam int SRC_RX_TOUT   = 8;
  localparam int SRC_MODEM     = 9;
  localparam int SRC_TX_TRIG   = 10;
  localparam int SRC_TX_NFULL  = 11;
  localparam int SRC_TX_OVFL   = 12;
  localparam int SRC_RX_BREAK  = 13;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SET  = 3'd0,
    ADR_CLR  = 3'd1,
    ADR_MASK = 3'd2,
    ADR_STAT = 3'd3,
    ADR_LIVE = 3'd4
  } regAddrE;

  typedef struct packed {
    logic             setMask;
    logic             clrMask;
    logic             clrStat;
    logic [SRC_N-1:0] bits;
  } strobeT;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SRC_N-1:0]  maskQ,
  input  logic [SRC_N-1:0]  statQ,
  input  logic [SRC_N-1:0]  liveIn,
  output strobeT            strb,
  output logic [DATA_W-1:0] rdData
);
  logic unusedHi;
  assign unusedHi = ^wrData[DATA_W-1:SRC_N];

  always_comb begin
    strb      = '0;
    strb.bits = wrData[SRC_N-1:0];
    if (wrEn) begin
      case (addr)
        ADR_SET:  strb.setMask = 1'b1;
        ADR_CLR:  strb.clrMask = 1'b1;
        ADR_STAT: strb.clrStat = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADR_MASK: rdData = DATA_W'(maskQ);
      ADR_STAT: rdData = DATA_W'(statQ);
      ADR_LIVE: rdData = DATA_W'(liveIn);
      default:  rdData = '0;
    endcase
  end

  // R4
  wo_readback_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADR_SET || addr == ADR_CLR) |-> rdData == '0);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.setMask, strb.clrMask, strb.clrStat}) <= 1);
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [SRC_N-1:0] evtIn,
  output logic [SRC_N-1:0] maskQ,
  output logic [SRC_N-1:0] statQ,
  output logic             irqOut
);
  logic [SRC_N-1:0] maskNext;
  logic [SRC_N-1:0] statNext;
  logic [SRC_N-1:0] ackBits;

  always_comb begin
    maskNext = maskQ;
    if (strb.setMask) maskNext = maskNext | strb.bits;
    if (strb.clrMask) maskNext = maskNext & ~strb.bits;
  end

  // the event term is applied last, so it wins over an acknowledge
  assign ackBits  = strb.clrStat ? strb.bits : '0;
  assign statNext = (statQ & ~ackBits) | (evtIn & maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      statQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      maskQ  <= maskNext;
      statQ  <= statNext;
      irqOut <= |statNext;
    end
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask |=> ((maskQ & $past(strb.bits)) == $past(strb.bits)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMask |=> ((maskQ & $past(strb.bits)) == '0));

  // R5
  gated_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(maskQ)) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStat |=> ((~statQ & $past(statQ)) == '0));

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(evtIn) & $past(maskQ)) & ~statQ) == '0));

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|statQ));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SRC_N-1:0]  srcEvt,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  strobeT           strb;
  logic [SRC_N-1:0] maskQ;
  logic [SRC_N-1:0] statQ;

  uart_irq_decode u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .maskQ(maskQ), .statQ(statQ), .liveIn(srcEvt),
    .strb(strb), .rdData(rdData)
  );

  uart_irq_core u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(srcEvt),
    .maskQ(maskQ), .statQ(statQ), .irqOut(irqOut)
  );
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [13:0] srcEvt = '0;
  logic [31:0] rdData;
  logic        irqOut;

  typedef struct {
    logic [31:0] data;
    logic        irq;
    string       req;
  } expT;

  expT    sbq[$];
  int     checks = 0;
  int     errors = 0;
  bit     done = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .srcEvt(srcEvt), .rdData(rdData), .irqOut(irqOut)
  );

  // monitor: compares three ns after the falling edge
  always @(negedge clk) begin
    #3;
    if (sbq.size() > 0) begin
      expT e;
      e = sbq.pop_front();
      checks++;
      if (rdData !== e.data || irqOut !== e.irq) begin
        errors++;
        $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                 e.req, rdData, irqOut, e.data, e.irq);
      end
    end
  end

  task automatic expectRd(input logic [2:0] a, input logic [31:0] d,
                          input logic i, input string req);
    expT e;
    @(negedge clk);
    wrEn = 1'b0;
    addr = a;
    e.data = d; e.irq = i; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d,
                       input logic [13:0] ev);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; srcEvt = ev;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; srcEvt = '0;
  endtask

  task automatic pulse(input logic [13:0] ev);
    @(negedge clk);
    srcEvt = ev;
    @(negedge clk);
    srcEvt = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectRd(3'd2, 32'h0, 1'b0, "R1 mask");
    expectRd(3'd3, 32'h0, 1'b0, "R1 status");
    // R2 set bits
    regWr(3'd0, 32'h2005, '0);
    expectRd(3'd2, 32'h2005, 1'b0, "R2 set");
    regWr(3'd0, 32'h0, '0);
    expectRd(3'd2, 32'h2005, 1'b0, "R2 zero bits");
    // R10 high data bits ignored
    regWr(3'd0, 32'hFFFF_0010, '0);
    expectRd(3'd2, 32'h2015, 1'b0, "R10 high bits");
    // R4 write-only addresses
    expectRd(3'd0, 32'h0, 1'b0, "R4 set addr");
    expectRd(3'd1, 32'h0, 1'b0, "R4 clr addr");
    // R3 clear bits
    regWr(3'd1, 32'h0004, '0);
    expectRd(3'd2, 32'h2011, 1'b0, "R3 clear");
    regWr(3'd1, 32'h0, '0);
    expectRd(3'd2, 32'h2011, 1'b0, "R3 zero bits");
    // R10 mask address not writable
    regWr(3'd2, 32'h3FFF, '0);
    expectRd(3'd2, 32'h2011, 1'b0, "R10 mask write");
    // R5 and R8: only enabled sources latch
    pulse(14'h3FFF);
    expectRd(3'd3, 32'h2011, 1'b1, "R5 gated latch");
    // R9 live view shows masked sources
    @(negedge clk);
    srcEvt = 14'h0A5A;
    expectRd(3'd4, 32'h0A5A, 1'b1, "R9 live");
    @(negedge clk);
    srcEvt = '0;
    expectRd(3'd3, 32'h2011, 1'b1, "R9 status after live");
    // R6 acknowledge and stickiness
    regWr(3'd3, 32'h0001, '0);
    expectRd(3'd3, 32'h2010, 1'b1, "R6 ack");
    regWr(3'd3, 32'h0, '0);
    expectRd(3'd3, 32'h2010, 1'b1, "R6 zero bits");
    regWr(3'd1, 32'h2010, '0);
    expectRd(3'd3, 32'h2010, 1'b1, "R6 mask cleared keeps status");
    expectRd(3'd2, 32'h0001, 1'b1, "R3 mask after clear");
    // R8 interrupt drops when all status cleared
    regWr(3'd3, 32'h3FFF, '0);
    expectRd(3'd3, 32'h0, 1'b0, "R8 irq low");
    // R7 event wins over clear
    pulse(14'h0001);
    expectRd(3'd3, 32'h0001, 1'b1, "R7 setup");
    regWr(3'd3, 32'h0001, 14'h0001);
    expectRd(3'd3, 32'h0001, 1'b1, "R7 event wins");
    regWr(3'd3, 32'h0001, '0);
    expectRd(3'd3, 32'h0, 1'b0, "R7 clear alone");
    // R5 enable in same cycle as event is not recorded
    regWr(3'd0, 32'h0100, 14'h0100);
    expectRd(3'd3, 32'h0, 1'b0, "R5 same-edge enable");
    pulse(14'h0100);
    expectRd(3'd3, 32'h0100, 1'b1, "R5 later event");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule